// File: doc/BRIEF.md
# Memory-Mapped Interrupt Aggregator with Pulse Latching

This block collects up to sixty-four interrupt lines behind an APB slave port and drives a single request line to the processor. Each line is fixed at build time as either level-sensitive or pulse-type. A level line is seen live. A pulse line is caught in a sticky flag bit that holds it until software clears the bit. Per-source enable bits gate both kinds of line into two 32-bit pending words. A global enable bit then gates the OR of all pending bits onto the request output.

The block also holds a table of sixty-four byte-wide mapping slots that software may rewrite. Reset loads the table with the identity arrangement. A small bus state machine follows the APB phases and commits a write in the access cycle. It has three states, ST_IDLE, ST_SETUP and ST_ACCESS:

- ST_IDLE moves to ST_SETUP when select rises without enable.
- ST_SETUP moves to ST_ACCESS when enable joins select. It stays in ST_SETUP while select is held without enable, and falls back to ST_IDLE if select drops.
- ST_ACCESS moves to ST_SETUP on a back-to-back transfer, and to ST_IDLE otherwise.

Top module: `apb_irq_ctrl`

## Requirements
- R1: After reset, all enable bits, all flag bits and the control register are zero, the pending words read zero and `irq_o` is low.
- R2: The enable word for sources 0-31 is at offset 0x10, and the one for sources 32-63 is at offset 0x28. Both read back the value last written.
- R3: Sources 0-15 and 32-47 are level type. Their pending bit is the enable bit ANDed with the live input, with no register in the path.
- R4: Sources 16-31 and 48-63 are pulse type. An input high for one cycle sets the matching flag bit on the next clock edge, and the bit then holds. The flag words are at 0x08 (sources 0-31) and 0x20 (sources 32-63). Capture happens whether or not the source is enabled.
- R5: A write to a flag word clears each bit written as 0 and leaves each bit written as 1 unchanged. A pulse arriving in the same cycle as a clearing write leaves the bit set.
- R6: For pulse sources, the pending bit is the enable bit ANDed with the flag bit. A flag bit with its enable at zero gives no pending bit.
- R7: The pending words at 0x14 (sources 0-31) and 0x2C (sources 32-63) are read-only. Writes to them change no state.
- R8: The control word at 0x00 keeps only bit 31, the global enable; its other bits read 0. `irq_o` is high exactly when the global enable is set and any pending bit is set, with no register in the path.
- R9: The mapping words at 0x40 to 0x7C are fully writable. Word k resets to bytes 4k, 4k+1, 4k+2, 4k+3 in bits 31:24, 23:16, 15:8, 7:0. For example, 0x40 reads 0x00010203 and 0x7C reads 0x3C3D3E3F.
- R10: Reads of any other offset return zero, and writes to them are ignored. `pready` is always 1 and `pslverr` is always 0.
- R11: Flag bits of level sources always read zero, even after a short pulse on the input.
- R12: A write takes effect at the clock edge that ends the access cycle. Read data is valid during the access cycle with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and block clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| irq_src_i | input | NUM_SRC | Interrupt source lines |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Level-source pending bits and `irq_o` follow the inputs in the same cycle, so the bench samples them one time unit after it drives the input at a falling edge. A pulse reaches its flag bit one rising edge after the input rises, and register writes land on the edge that ends the access cycle. Because of this, every flag, pending or control result is read only after that edge, in a later read transfer. Read data is combinational within the access cycle, and it is sampled one time unit after enable rises. The same-cycle race between a clearing write and a new pulse is built by placing the pulse exactly in the access cycle of the write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS
    } apb_phase_e;

    localparam int unsigned GRP_W     = 32;
    localparam int unsigned OFF_CTRL  = 32'h000;
    localparam int unsigned OFF_MAP   = 32'h040;
    localparam int unsigned GRP_PITCH = 32'h018;
    localparam int unsigned GIE_BIT   = 31;

    function automatic int unsigned off_enable(input int unsigned g);
        return 32'h010 + g * GRP_PITCH;
    endfunction

    function automatic int unsigned off_pending(input int unsigned g);
        return off_enable(g) + 4;
    endfunction

    function automatic int unsigned off_flag(input int unsigned g);
        return off_enable(g) - 8;
    endfunction

    function automatic logic [31:0] map_reset_word(input int unsigned k);
        logic [7:0] b;
        b = 8'(4 * k);
        return {b, b + 8'd1, b + 8'd2, b + 8'd3};
    endfunction

endpackage

// File: rtl/irqc_bus_fsm.sv
module irqc_bus_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb
);

    apb_phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            ST_SETUP:  begin
                if (psel && penable) state_d = ST_ACCESS;
                else if (psel)       state_d = ST_SETUP;
                else                 state_d = ST_IDLE;
            end
            ST_ACCESS: state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_stb = 1'b0;
        unique case (state_q)
            ST_SETUP: wr_stb = psel && penable && pwrite;
            ST_IDLE, ST_ACCESS: wr_stb = 1'b0;
            default:  wr_stb = 1'b0;
        endcase
    end

endmodule

// File: rtl/irqc_src_group.sv
module irqc_src_group #(
    parameter int unsigned      W     = 32,
    parameter logic [W-1:0]     PULSE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         en_we,
    input  logic         flag_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] flag_q,
    output logic [W-1:0] pend_o
);

    logic [W-1:0] flag_kept;

    always_comb flag_kept = flag_we ? (flag_q & wdata) : flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (en_we) en_q <= wdata;
            flag_q <= (flag_kept | src_i) & PULSE;
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (PULSE[b]) begin : g_pulse
            assign pend_o[b] = en_q[b] & flag_q[b];
        end else begin : g_level
            assign pend_o[b] = en_q[b] & src_i[b];
        end
    end

endmodule

// File: rtl/irqc_map_table.sv
module irqc_map_table
    import irqc_pkg::*;
#(
    parameter int unsigned WORDS = 16,
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);

    logic [31:0] slot_q [WORDS];

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      slot_q[k] <= map_reset_word(k);
            else if (we && idx == IDX_W'(k)) slot_q[k] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < WORDS; k++)
            if (idx == IDX_W'(k)) rdata = slot_q[k];
    end

endmodule

// File: rtl/apb_irq_ctrl.sv
module apb_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned           NUM_SRC    = 64,
    parameter int unsigned           ADDR_W     = 12,
    parameter logic [NUM_SRC-1:0]    PULSE_MASK = 64'hFFFF_0000_FFFF_0000
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_SRC-1:0] irq_src_i,
    output logic               irq_o
);

    localparam int unsigned NUM_GRP   = NUM_SRC / GRP_W;
    localparam int unsigned MAP_WORDS = NUM_SRC / 4;
    localparam int unsigned MIDX_W    = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;

    logic               wr_stb;
    logic               gie_q;
    logic [NUM_SRC-1:0] en_all, flag_all, pend_all;
    logic               map_hit;
    logic [ADDR_W-1:0]  map_rel;
    logic [MIDX_W-1:0]  map_idx;
    logic [31:0]        map_rdata;

    irqc_bus_fsm u_fsm (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_stb  (wr_stb)
    );

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn)
            gie_q <= 1'b0;
        else if (wr_stb && paddr == ADDR_W'(OFF_CTRL))
            gie_q <= pwdata[GIE_BIT];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic en_we, flag_we;
        assign en_we   = wr_stb && paddr == ADDR_W'(off_enable(g));
        assign flag_we = wr_stb && paddr == ADDR_W'(off_flag(g));

        irqc_src_group #(
            .W     (GRP_W),
            .PULSE (PULSE_MASK[g*GRP_W +: GRP_W])
        ) u_grp (
            .clk     (pclk),
            .rst_n   (presetn),
            .src_i   (irq_src_i[g*GRP_W +: GRP_W]),
            .en_we   (en_we),
            .flag_we (flag_we),
            .wdata   (pwdata),
            .en_q    (en_all[g*GRP_W +: GRP_W]),
            .flag_q  (flag_all[g*GRP_W +: GRP_W]),
            .pend_o  (pend_all[g*GRP_W +: GRP_W])
        );
    end

    assign map_rel = paddr - ADDR_W'(OFF_MAP);
    assign map_hit = (paddr >= ADDR_W'(OFF_MAP)) &&
                     (paddr <  ADDR_W'(OFF_MAP + 4 * MAP_WORDS)) &&
                     (paddr[1:0] == 2'b00);
    assign map_idx = map_rel[2 +: MIDX_W];

    irqc_map_table #(.WORDS(MAP_WORDS)) u_map (
        .clk   (pclk),
        .rst_n (presetn),
        .we    (wr_stb && map_hit),
        .idx   (map_idx),
        .wdata (pwdata),
        .rdata (map_rdata)
    );

    always_comb begin
        prdata = '0;
        if (paddr == ADDR_W'(OFF_CTRL))
            prdata[GIE_BIT] = gie_q;
        else if (map_hit)
            prdata = map_rdata;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (paddr == ADDR_W'(off_enable(g)))  prdata = en_all[g*GRP_W +: GRP_W];
            if (paddr == ADDR_W'(off_pending(g))) prdata = pend_all[g*GRP_W +: GRP_W];
            if (paddr == ADDR_W'(off_flag(g)))    prdata = flag_all[g*GRP_W +: GRP_W];
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq_o   = gie_q & (|pend_all);

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned        NUM_SRC    = 64,
    parameter int unsigned        ADDR_W     = 12,
    parameter logic [NUM_SRC-1:0] PULSE_MASK = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_stb,
    input logic [ADDR_W-1:0]  paddr,
    input logic [31:0]        pwdata,
    input logic [NUM_SRC-1:0] src_i,
    input logic [NUM_SRC-1:0] en_all,
    input logic [NUM_SRC-1:0] flag_all,
    input logic [NUM_SRC-1:0] pend_all,
    input logic               gie_q,
    input logic               irq_o
);

    assert_pulse_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_all & $past(src_i & PULSE_MASK)) == $past(src_i & PULSE_MASK)));

    assert_no_spurious_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_all & ~$past(flag_all | (src_i & PULSE_MASK))) == '0));

    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && paddr == ADDR_W'(12'h008)) |=>
        ((flag_all[31:0] & ~$past(pwdata) & ~$past(src_i[31:0])) == '0));

    assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && paddr == ADDR_W'(12'h010)) |=> (en_all[31:0] == $past(pwdata)));

    assert_pending_readonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (paddr == ADDR_W'(12'h014) || paddr == ADDR_W'(12'h02C))) |=>
        $stable(en_all));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie_q && pend_all != '0));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_q |-> !irq_o);

endmodule

bind apb_irq_ctrl irqc_checker #(
    .NUM_SRC    (NUM_SRC),
    .ADDR_W     (ADDR_W),
    .PULSE_MASK (PULSE_MASK)
) u_chk (
    .clk      (pclk),
    .rst_n    (presetn),
    .wr_stb   (wr_stb),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .src_i    (irq_src_i),
    .en_all   (en_all),
    .flag_all (flag_all),
    .pend_all (pend_all),
    .gie_q    (gie_q),
    .irq_o    (irq_o)
);

// File: tb/test_apb_irq_ctrl.sv
`timescale 1ns/1ps
module test_apb_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq_o;
    logic [63:0] src = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    apb_irq_ctrl i_apb_irq_ctrl (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_src_i(src), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  req;
        logic [11:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd1,  12'h010, 32'h0000_0000},  // R1
        '{1'b0, 4'd1,  12'h028, 32'h0000_0000},  // R1
        '{1'b0, 4'd1,  12'h000, 32'h0000_0000},  // R1
        '{1'b0, 4'd1,  12'h008, 32'h0000_0000},  // R1
        '{1'b1, 4'd2,  12'h010, 32'hA5A5_0F0F},
        '{1'b0, 4'd2,  12'h010, 32'hA5A5_0F0F},  // R2
        '{1'b1, 4'd2,  12'h028, 32'h1234_5678},
        '{1'b0, 4'd2,  12'h028, 32'h1234_5678},  // R2
        '{1'b1, 4'd7,  12'h014, 32'hFFFF_FFFF},
        '{1'b0, 4'd7,  12'h014, 32'h0000_0000},  // R7
        '{1'b0, 4'd7,  12'h010, 32'hA5A5_0F0F},  // R7 enable untouched
        '{1'b1, 4'd8,  12'h000, 32'hFFFF_FFFF},
        '{1'b0, 4'd8,  12'h000, 32'h8000_0000},  // R8
        '{1'b0, 4'd9,  12'h040, 32'h0001_0203},  // R9
        '{1'b0, 4'd9,  12'h07C, 32'h3C3D_3E3F},  // R9
        '{1'b1, 4'd9,  12'h044, 32'hDEAD_BEEF},
        '{1'b0, 4'd9,  12'h044, 32'hDEAD_BEEF},  // R9
        '{1'b1, 4'd10, 12'h004, 32'hFFFF_FFFF},
        '{1'b0, 4'd10, 12'h004, 32'h0000_0000},  // R10
        '{1'b0, 4'd10, 12'h080, 32'h0000_0000},  // R10
        '{1'b0, 4'd10, 12'h00C, 32'h0000_0000}   // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1;
        #1 d = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk); src[i] = 1'b1;
        @(negedge clk); src[i] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; src = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();
        #1;
        check("R1 irq_o", {31'b0, irq_o}, 32'h0);
        check("R10 pready", {31'b0, pready}, 32'h1);
        check("R10 pslverr", {31'b0, pslverr}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) apb_write(VECS[v].addr, VECS[v].data);
            else begin
                apb_read(VECS[v].addr, d);
                check($sformatf("R%0d vector %0d", VECS[v].req, v), d, VECS[v].data);
            end
        end

        // R3 level sources
        do_reset();
        apb_write(12'h010, 32'h0000_00FF);
        apb_write(12'h000, 32'h8000_0000);
        @(negedge clk); src[3] = 1'b1;
        #1 check("R3 irq with level high", {31'b0, irq_o}, 32'h1);
        apb_read(12'h014, d);
        check("R3 pending low", d, 32'h0000_0008);
        @(negedge clk); src[3] = 1'b0;
        #1 check("R3 irq drops with level", {31'b0, irq_o}, 32'h0);
        @(negedge clk); src[8] = 1'b1;
        #1 check("R3 disabled level", {31'b0, irq_o}, 32'h0);
        @(negedge clk); src[8] = 1'b0;

        // R4 / R6 pulse sources
        pulse(20);
        apb_read(12'h008, d);
        check("R4 flag captured while disabled", d, 32'h0010_0000);
        apb_read(12'h014, d);
        check("R6 no pending without enable", d, 32'h0);
        apb_write(12'h010, 32'h0010_00FF);
        apb_read(12'h014, d);
        check("R6 pending from flag", d, 32'h0010_0000);
        check("R4 irq held after pulse", {31'b0, irq_o}, 32'h1);

        // R5 write-to-clear
        apb_write(12'h008, 32'hFFFF_FFFF);
        apb_read(12'h008, d);
        check("R5 ones leave flag", d, 32'h0010_0000);
        apb_write(12'h008, ~32'h0010_0000);
        apb_read(12'h008, d);
        check("R5 zero clears flag", d, 32'h0);
        #1 check("R5 irq after clear", {31'b0, irq_o}, 32'h0);

        // R5 race: pulse in the access cycle of a clearing write
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h008; pwdata = 32'h0;
        @(negedge clk); penable = 1'b1; src[21] = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0; src[21] = 1'b0;
        apb_read(12'h008, d);
        check("R5 pulse wins over clear", d, 32'h0020_0000);

        // R11 level-source flags stay zero
        pulse(5);
        apb_read(12'h008, d);
        check("R11 level flag zero", d, 32'h0020_0000);
        #1 check("R6 unenabled flag no irq", {31'b0, irq_o}, 32'h0);

        // High word
        pulse(50);
        apb_read(12'h020, d);
        check("R4 high flag", d, 32'h0004_0000);
        apb_write(12'h028, 32'h0004_0002);
        @(negedge clk); src[33] = 1'b1;
        apb_read(12'h02C, d);
        check("R3 R6 high pending", d, 32'h0004_0002);

        // R8 global gate
        apb_write(12'h000, 32'h0);
        #1 check("R8 irq gated off", {31'b0, irq_o}, 32'h0);
        apb_read(12'h02C, d);
        check("R8 pending unaffected by gate", d, 32'h0004_0002);
        apb_write(12'h000, 32'h8000_0000);
        #1 check("R8 irq restored", {31'b0, irq_o}, 32'h1);
        @(negedge clk); src[33] = 1'b0;
        apb_write(12'h020, 32'h0);
        #1 check("R12 irq low after clear write", {31'b0, irq_o}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule